// File: doc/BRIEF.md
# ACPI Memory Power State Sequencer

This block is the digital core of a standby-rail controller for suspend-to-RAM memory power. It watches the active-low sleep-state lines, an active-low enable for the 5V dual rail in soft-off, an external power-good line and a supply qualifier. From these it walks a five-state machine: mechanical off, soft-off with the dual rail dark, soft-off with the dual rail lit, full power and suspend. In each state it drives the enables for the standby-fed and main-fed 5V dual switches and for three linear regulator rails.

The analog soft-start capacitor is replaced by a digital ramp counter. Two transitions go through the ramp: lighting the dual rail and bringing up the regulators. On each of them the block raises a ramp request, and it enters the destination state only after the counter has reached its limit. Under-voltage comparator flags are watched only in full power and suspend, and a fault pulls the shared power-good line low.

A mode pin selects between two uses of the regulator pins. In one mode all three pins are regulators, and the third regulator starts early to spread the inrush. In the other mode the second and third pins serve as a bus terminator, so only the first regulator is monitored. Every pin input is synchronized before it is used.

Top module: `acpi_mem_pwr_seq`

## Requirements
- R1: While reset is held and after it is released, the state code is 0 (mechanical off) and every enable, the ramp request, ramp done and the power-good pull are 0. State codes: 0 mechanical off, 1 soft-off dark, 2 soft-off lit, 3 full power, 4 suspend.
- R2: With the supply qualifier high, mechanical off moves to soft-off dark without a ramp. With the qualifier low, any state goes to mechanical off on the next edge.
- R3: Soft-off dark ramps to soft-off lit when the dual-rail enable pin is 0, or when both sleep lines are 1.
- R4: In soft-off lit, both sleep lines at 1 ramp to full power, and this takes priority. Otherwise the dual-rail enable pin at 1 returns the block to soft-off dark.
- R5: In full power, a suspend-line 0 with the soft-off line at 1 enters suspend. A soft-off line of 0 enters soft-off lit if the dual-rail enable pin is 0, and soft-off dark otherwise.
- R6: Suspend wakes to full power only when both sleep lines and the sampled power-good are all 1. A soft-off line of 0 leaves suspend for soft-off lit or dark, chosen as in R5.
- R7: Settled outputs per state. Mechanical off and soft-off dark: all off. Soft-off lit: standby switch only. Full power: main switch and regulators 2:0 all on. Suspend: standby switch and all regulators on. The two switches are never on together.
- R8: A ramp asserts the ramp request while its start condition holds. Ramp done rises RAMP_MAX edges later, and the destination state follows on the next edge. If the request is withdrawn earlier, the counter restarts and the state stays put.
- R9: The power-good pull is driven only from full power or suspend, and only on an under-voltage flag.
- R10: With mode pin 0, only under-voltage flag bit 0 can drive the pull. With mode pin 1, any of the three flag bits can.
- R11: During the regulator ramp with mode pin 1, regulator enable bit 2 turns on at the start of the ramp and bits 1:0 turn on once the counter reaches half of its range. With mode pin 0, all three turn on at the start.
- R12: Every pin input passes through two flops, so a pin change alters the state on the third rising edge after it and no earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok_i | input | 1 | Qualified supply power-on condition |
| slp3_n_i | input | 1 | Suspend sleep line, active low |
| slp5_n_i | input | 1 | Soft-off sleep line, active low |
| dual_en_n_i | input | 1 | Dual rail enable in soft-off, active low |
| pgood_i | input | 1 | Sampled level of the power-good line |
| mode_b_i | input | 1 | 1: three regulators; 0: one regulator plus bus terminator |
| uv_flag_i | input | 3 | Per-rail under-voltage comparator flags |
| dual_sb_en_o | output | 1 | Standby-fed 5V dual switch enable |
| dual_main_en_o | output | 1 | Main-fed 5V dual switch enable |
| reg_en_o | output | 3 | Linear regulator enables, bit 0 is the first rail |
| pgood_pull_o | output | 1 | Drive the open-drain power-good line low |
| ramp_req_o | output | 1 | Soft-start ramp in progress |
| ramp_done_o | output | 1 | Ramp counter at its limit |
| state_o | output | 3 | Current state code |

## Verification
A directed walk covers every legal arc. It tells the two soft-off destinations apart by the dual-rail enable pin, and it tells a wake that is held off by power-good from one that is granted. Timed probes catch a ramp that finishes one edge early or late, a stagger in mode 1 as opposed to a simultaneous start in mode 0, and a synchronizer with the wrong depth. An aborted ramp pulse shows that the counter restarts rather than resumes. Seeded random pin sets, each held until the machine settles, are compared with a bench model of the settled state, the output table and the under-voltage scope in both modes.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    ST_G3    = 3'd0,
    ST_S5OFF = 3'd1,
    ST_S5ON  = 3'd2,
    ST_S0    = 3'd3,
    ST_S3    = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwrseq_ramp.sv
module pwrseq_ramp #(
  parameter int RAMP_MAX = 511,
  parameter int LEAD     = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic done_o,
  output logic lead_hit_o
);
  localparam int CW = $clog2(RAMP_MAX + 1);
  localparam logic [CW-1:0] LIMIT  = CW'(RAMP_MAX);
  localparam logic [CW-1:0] LEAD_C = CW'(LEAD);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_limit;

  assign at_limit   = (cnt_q == LIMIT);
  assign done_o     = req_i && at_limit;
  assign lead_hit_o = req_i && (cnt_q >= LEAD_C);

  always_comb begin
    if (!req_i || done_o) cnt_d = '0;
    else if (at_limit)    cnt_d = cnt_q;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8
  ramp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_i) |-> cnt_q == '0);
endmodule

// File: rtl/pwrseq_uvmon.sv
module pwrseq_uvmon
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state_i,
  input  logic       mode_b_i,
  input  logic [2:0] uv_i,
  output logic       pull_o
);
  logic watch_en, fault, pull_q, pull_d;

  assign watch_en = (state_i == ST_S0) || (state_i == ST_S3);
  assign fault    = mode_b_i ? (|uv_i) : uv_i[0];
  assign pull_d   = watch_en && fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_q <= 1'b0;
    else        pull_q <= pull_d;
  end

  assign pull_o = pull_q;

  // R10
  mode_a_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_q && !$past(mode_b_i)) |-> $past(uv_i[0]));
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_s,
  input  logic       slp3_n_s,
  input  logic       slp5_n_s,
  input  logic       dual_en_n_s,
  input  logic       pgood_s,
  input  logic       mode_b_s,
  input  logic       ramp_done_i,
  input  logic       lead_hit_i,
  output pwr_state_e state_o,
  output logic       ramp_req_o,
  output logic       dual_sb_o,
  output logic       dual_main_o,
  output logic [2:0] reg_en_o
);
  pwr_state_e state_q, state_d;
  logic       wake;
  logic       req;
  pwr_state_e off_dest;

  assign wake     = slp3_n_s && slp5_n_s;
  assign off_dest = dual_en_n_s ? ST_S5OFF : ST_S5ON;

  always_comb begin
    state_d = state_q;
    req     = 1'b0;
    unique case (state_q)
      ST_G3:    state_d = ST_S5OFF;
      ST_S5OFF: begin
        req = !dual_en_n_s || wake;
        if (req && ramp_done_i) state_d = ST_S5ON;
      end
      ST_S5ON: begin
        if (wake) begin
          req = 1'b1;
          if (ramp_done_i) state_d = ST_S0;
        end else if (dual_en_n_s) begin
          state_d = ST_S5OFF;
        end
      end
      ST_S0: begin
        if (!slp5_n_s)      state_d = off_dest;
        else if (!slp3_n_s) state_d = ST_S3;
      end
      ST_S3: begin
        if (!slp5_n_s)             state_d = off_dest;
        else if (wake && pgood_s)  state_d = ST_S0;
      end
      default: state_d = ST_G3;
    endcase
    if (!por_s) begin
      state_d = ST_G3;
      req     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_G3;
    else        state_q <= state_d;
  end

  always_comb begin
    dual_sb_o   = 1'b0;
    dual_main_o = 1'b0;
    reg_en_o    = 3'b000;
    unique case (state_q)
      ST_S5OFF: dual_sb_o = req;
      ST_S5ON: begin
        dual_sb_o = 1'b1;
        if (req) reg_en_o = mode_b_s ? {1'b1, lead_hit_i, lead_hit_i} : 3'b111;
      end
      ST_S0: begin
        dual_main_o = 1'b1;
        reg_en_o    = 3'b111;
      end
      ST_S3: begin
        dual_sb_o = 1'b1;
        reg_en_o  = 3'b111;
      end
      default: ;
    endcase
  end

  assign state_o    = state_q;
  assign ramp_req_o = req;

  // R2
  por_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_s |=> state_q == ST_G3);
  // R6
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_S0 && $past(state_q) == ST_S3) |-> $past(pgood_s));
  // R8
  ramp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_S5ON && $past(state_q) == ST_S5OFF) ||
     (state_q == ST_S0 && $past(state_q) == ST_S5ON)) |-> $past(ramp_done_i));
  // R7
  switch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dual_sb_o, dual_main_o}));
  // R11
  stagger_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en_o[0] |-> reg_en_o[2]);
endmodule

// File: rtl/acpi_mem_pwr_seq.sv
module acpi_mem_pwr_seq
  import pwrseq_pkg::*;
#(
  parameter int RAMP_MAX    = 511,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok_i,
  input  logic       slp3_n_i,
  input  logic       slp5_n_i,
  input  logic       dual_en_n_i,
  input  logic       pgood_i,
  input  logic       mode_b_i,
  input  logic [2:0] uv_flag_i,
  output logic       dual_sb_en_o,
  output logic       dual_main_en_o,
  output logic [2:0] reg_en_o,
  output logic       pgood_pull_o,
  output logic       ramp_req_o,
  output logic       ramp_done_o,
  output logic [2:0] state_o
);
  localparam int LEAD   = (RAMP_MAX + 1) / 2;
  localparam int NPINS  = 9;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [NPINS-1:0] pins_raw, pins_s;
  logic             por_s, s3_s, s5_s, den_s, pg_s, mb_s;
  logic [2:0]       uv_s;
  logic             ramp_req, ramp_done, lead_hit;
  pwr_state_e       fsm_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign pins_raw = {por_ok_i, slp3_n_i, slp5_n_i, dual_en_n_i, pgood_i, mode_b_i, uv_flag_i};

  pwrseq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign {por_s, s3_s, s5_s, den_s, pg_s, mb_s, uv_s} = pins_s;

  pwrseq_ramp #(.RAMP_MAX(RAMP_MAX), .LEAD(LEAD)) u_ramp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_i      (ramp_req),
    .done_o     (ramp_done),
    .lead_hit_o (lead_hit)
  );

  pwrseq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .por_s       (por_s),
    .slp3_n_s    (s3_s),
    .slp5_n_s    (s5_s),
    .dual_en_n_s (den_s),
    .pgood_s     (pg_s),
    .mode_b_s    (mb_s),
    .ramp_done_i (ramp_done),
    .lead_hit_i  (lead_hit),
    .state_o     (fsm_state),
    .ramp_req_o  (ramp_req),
    .dual_sb_o   (dual_sb_en_o),
    .dual_main_o (dual_main_en_o),
    .reg_en_o    (reg_en_o)
  );

  pwrseq_uvmon u_uvmon (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .state_i  (fsm_state),
    .mode_b_i (mb_s),
    .uv_i     (uv_s),
    .pull_o   (pgood_pull_o)
  );

  assign ramp_req_o  = ramp_req;
  assign ramp_done_o = ramp_done;
  assign state_o     = fsm_state;

  // R9
  uv_scope_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    pgood_pull_o |-> ($past(fsm_state) == ST_S0 || $past(fsm_state) == ST_S3));
endmodule

// File: tb/acpi_mem_pwr_seq_bench.sv
`timescale 1ns/1ps
module acpi_mem_pwr_seq_bench;
  localparam int RAMP_MAX = 15;
  localparam int HOLD     = 3 * (RAMP_MAX + 3) + 8;
  localparam int WD_NS    = 400000;

  logic clk = 1'b0;
  logic rst_n;
  logic por, s3n, s5n, den, pg, mb;
  logic [2:0] uv;
  logic sb, mn, pull, rq, dn;
  logic [2:0] regs, st;
  int vecs = 0, miss = 0;
  bit done_flag = 0;
  logic [2:0] exp_st;

  always #2 clk = ~clk;

  acpi_mem_pwr_seq #(.RAMP_MAX(RAMP_MAX)) u_acpi_mem_pwr_seq (
    .clk(clk), .rst_n(rst_n), .por_ok_i(por), .slp3_n_i(s3n), .slp5_n_i(s5n),
    .dual_en_n_i(den), .pgood_i(pg), .mode_b_i(mb), .uv_flag_i(uv),
    .dual_sb_en_o(sb), .dual_main_en_o(mn), .reg_en_o(regs), .pgood_pull_o(pull),
    .ramp_req_o(rq), .ramp_done_o(dn), .state_o(st)
  );

  function automatic logic [2:0] f_step(logic [2:0] s, logic p, logic a3, logic a5, logic d, logic g);
    if (!p) return 3'd0;
    case (s)
      3'd0: return 3'd1;
      3'd1: if (!d || (a3 && a5)) return 3'd2;
      3'd2: if (a3 && a5) return 3'd3; else if (d) return 3'd1;
      3'd3: if (!a5) return d ? 3'd1 : 3'd2; else if (!a3) return 3'd4;
      3'd4: if (!a5) return d ? 3'd1 : 3'd2; else if (a3 && g) return 3'd3;
      default: return 3'd0;
    endcase
    return s;
  endfunction

  function automatic logic [2:0] f_settle(logic [2:0] s);
    logic [2:0] x = s;
    for (int i = 0; i < 6; i++) x = f_step(x, por, s3n, s5n, den, pg);
    return x;
  endfunction

  // R7 table: {sb, main, regs[2:0]}
  function automatic logic [4:0] f_outs(logic [2:0] s);
    case (s)
      3'd2: return 5'b10000;
      3'd3: return 5'b01111;
      3'd4: return 5'b10111;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic logic f_pull(logic [2:0] s);
    return (s == 3'd3 || s == 3'd4) && (mb ? (|uv) : uv[0]);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] expv);
    vecs++;
    if (act !== expv) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(logic p, logic a3, logic a5, logic d, logic g, logic m, logic [2:0] u);
    @(negedge clk);
    por = p; s3n = a3; s5n = a5; den = d; pg = g; mb = m; uv = u;
  endtask

  task automatic settle_check(string tag);
    exp_st = f_settle(exp_st);
    edges(HOLD);
    chk({tag, " state"}, {5'd0, st}, {5'd0, exp_st});
    chk({"R7 outputs ", tag}, {3'd0, sb, mn, regs}, {3'd0, f_outs(exp_st)});
    chk({"R8 idle ramp ", tag}, {6'd0, rq, dn}, 8'd0);
    chk({"R9 R10 pull ", tag}, {7'd0, pull}, {7'd0, f_pull(exp_st)});
  endtask

  initial begin
    #WD_NS;
    if (!done_flag) begin
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    por = 0; s3n = 1; s5n = 1; den = 1; pg = 0; mb = 1; uv = 3'b000;
    edges(3);
    // R1 during reset
    chk("R1 reset state", {5'd0, st}, 8'd0);
    chk("R1 reset outputs", {1'b0, sb, mn, regs, pull, rq}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    exp_st = 3'd0;
    settle_check("R1 after release");

    // R2 power-on qualifier
    drive(1, 0, 1, 1, 0, 1, 3'b000);
    settle_check("R2 to soft-off dark");

    // R8 aborted ramp
    drive(1, 0, 1, 0, 0, 1, 3'b000);
    edges(6);
    chk("R8 ramp requested", {6'd0, rq, sb}, 8'd3);
    chk("R8 not yet lit", {5'd0, st}, 8'd1);
    drive(1, 0, 1, 1, 0, 1, 3'b000);
    settle_check("R8 abort stays dark");

    // R3 dual enable pin lights the rail
    drive(1, 0, 1, 0, 0, 1, 3'b000);
    settle_check("R3 lit by enable pin");

    // R11 R8 R12 mode 1 regulator ramp timing
    drive(1, 1, 1, 0, 0, 1, 3'b000);
    edges(3);
    chk("R11 mode1 early rail", {5'd0, regs}, 8'b100);
    edges(RAMP_MAX - 1);
    chk("R8 done before entry", {6'd0, dn, st == 3'd2}, 8'd3);
    edges(1);
    chk("R8 entry after done", {5'd0, st}, 8'd3);
    exp_st = 3'd3;
    settle_check("R4 lit to full");

    // R12 synchronizer depth, R5 suspend entry
    drive(1, 0, 1, 0, 0, 1, 3'b000);
    edges(2);
    chk("R12 no change at edge 2", {5'd0, st}, 8'd3);
    edges(1);
    chk("R12 change at edge 3", {5'd0, st}, 8'd4);
    settle_check("R5 full to suspend");

    // R6 wake held by power-good
    drive(1, 1, 1, 0, 0, 1, 3'b000);
    settle_check("R6 wake blocked");
    drive(1, 1, 1, 0, 1, 1, 3'b000);
    settle_check("R6 wake granted");

    // R9 R10 under-voltage scope in full power
    drive(1, 1, 1, 0, 1, 1, 3'b010);
    settle_check("R10 mode1 rail1 fault");
    drive(1, 1, 1, 0, 1, 0, 3'b110);
    settle_check("R10 mode0 ignores rails 1 2");
    drive(1, 1, 1, 0, 1, 0, 3'b001);
    settle_check("R10 mode0 rail0 fault");

    // R5 soft-off with enable low, then R4 back to dark
    drive(1, 1, 0, 0, 1, 0, 3'b001);
    settle_check("R5 full to lit, R9 no pull");
    drive(1, 1, 0, 1, 1, 0, 3'b000);
    settle_check("R4 lit to dark");

    // R3 R4 double ramp via sleep lines, mode 0 simultaneous start
    drive(1, 1, 1, 1, 1, 0, 3'b000);
    edges(3 + RAMP_MAX + 3);
    chk("R3 reached lit", {5'd0, st}, 8'd2);
    chk("R11 mode0 all rails", {5'd0, regs}, 8'b111);
    exp_st = 3'd2;
    settle_check("R4 double ramp to full");

    // R6 suspend to dark
    drive(1, 0, 1, 1, 1, 0, 3'b000);
    settle_check("R5 into suspend");
    drive(1, 0, 0, 1, 1, 0, 3'b001);
    settle_check("R6 suspend to dark");

    // R2 qualifier loss from full power
    drive(1, 1, 1, 1, 1, 1, 3'b000);
    settle_check("R2 prep full");
    drive(0, 1, 1, 1, 1, 1, 3'b000);
    settle_check("R2 loss forces off");

    // random pin sets
    for (int i = 0; i < 60; i++) begin
      drive(($urandom % 8) != 0, $urandom % 2, ($urandom % 4) != 0, $urandom % 2,
            $urandom % 2, $urandom % 2, 3'($urandom % 8));
      settle_check("R3 R4 R5 R6 random");
    end

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule